// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block holds the exception bookkeeping of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). Each instruction picks up an exception flag, a 4-bit cause and its PC in fetch. These travel with it through the decode, execute and memory pipeline registers. Each stage adds its own fault source only if nothing earlier has already flagged the instruction. No exception acts where it is raised. The decision is made at a single commit point in the memory stage, and that is also where an external interrupt request enters.

When an exception or interrupt is taken at the commit point, the controller does four things. It writes the Cause and EPC registers. It kills every younger instruction in fetch, decode and execute, and clears their flags. It stops the faulting instruction from reaching writeback. It drives a redirect so that fetch loads the handler address on the next edge. Instructions that are not killed retire into writeback in order. The writeback valid and PC outputs let the surrounding datapath gate its register-file write.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is high, Cause and EPC read zero, writeback valid is low and no redirect is raised.
- R2: An instruction presented in fetch with `f_valid` in cycle t, and not killed, appears on `wb_valid`/`wb_pc` with its own PC in cycle t+4.
- R3: A fault recorded against an instruction raises `redirect` only in the cycle that instruction occupies the memory stage (cycle t+3 for fetch in cycle t), never earlier.
- R4: When several stages flag the same instruction, the cause recorded is that of the earliest stage; later stage faults do not overwrite it.
- R5: Cause codes are 4 bits: interrupt 4'h1, fetch PC address fault 4'h4, data address fault 4'h5, illegal opcode 4'hA, overflow 4'hC; reset value 4'h0.
- R6: When `irq` is high and the memory stage holds a valid instruction, an exception is taken with cause 4'h1, overriding any flagged cause; with an empty memory stage `irq` has no effect.
- R7: On a taken exception, Cause and EPC (the memory-stage instruction's PC) update on the next edge; otherwise both hold their values.
- R8: A taken exception kills the instructions in fetch, decode and execute: none of them writes back and none of their flags raises a later exception.
- R9: The instruction that takes the exception or interrupt does not write back.
- R10: `redirect` is raised in the same cycle the exception is taken, with `redirect_pc` equal to the `HANDLER_PC` parameter.
- R11: A stage fault input asserted while that stage holds no valid instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | A valid instruction is in fetch this cycle |
| f_pc | input | PC_W | PC of the fetch-stage instruction |
| f_pc_fault | input | 1 | PC address fault for the fetch-stage instruction |
| d_illegal | input | 1 | Illegal opcode for the decode-stage instruction |
| e_overflow | input | 1 | Arithmetic overflow for the execute-stage instruction |
| m_addr_fault | input | 1 | Data address fault for the memory-stage instruction |
| irq | input | 1 | External interrupt request, sampled at the commit point |
| redirect | output | 1 | Exception taken this cycle; fetch must load the handler |
| redirect_pc | output | PC_W | Handler address to load into fetch |
| wb_valid | output | 1 | An instruction retires in writeback this cycle |
| wb_pc | output | PC_W | PC of the retiring instruction |
| cause | output | 4 | Cause register |
| epc | output | PC_W | Exception PC register |

## Verification
The embedded assertions check several rules on every cycle. After a commit the decode, execute and memory registers must be empty, and the taking instruction must never retire. Cause and EPC must hold steady whenever nothing is taken. An interrupt that meets a valid memory-stage instruction must win with cause 4'h1, an empty commit stage must never take, and a cause already carried by an instruction must not be overwritten downstream. Other behaviour only shows up in the bench's scenarios, checked against a separate cycle model. These are the four-cycle retire latency and the earliest-stage cause when fetch, decode and execute all fault on one instruction. They also include the clearing of a killed younger instruction's flag, observed as the absence of any later redirect. The last is that faults are ignored on empty stages.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 4;
  // stage index: 0 fetch, 1 decode, 2 execute, 3 memory (commit point)
  localparam int NSTG = 4;
  localparam int COMMIT_STG = NSTG - 1;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 4'h0;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ     = 4'h1;
  localparam logic [CAUSE_W-1:0] CAUSE_PCFAULT = 4'h4;
  localparam logic [CAUSE_W-1:0] CAUSE_DADDR   = 4'h5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'hA;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF     = 4'hC;

  function automatic logic [CAUSE_W-1:0] stage_cause(input int s);
    case (s)
      0:       return CAUSE_PCFAULT;
      1:       return CAUSE_ILLEGAL;
      2:       return CAUSE_OVF;
      3:       return CAUSE_DADDR;
      default: return CAUSE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/exc_stage.sv
module exc_stage
  import exc_pkg::*;
#(
  parameter int                 PC_W = 32,
  parameter logic [CAUSE_W-1:0] CODE = CAUSE_NONE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kill,
  input  logic               in_valid,
  input  logic               in_exc,
  input  logic [CAUSE_W-1:0] in_cause,
  input  logic [PC_W-1:0]    in_pc,
  input  logic               fault,
  output logic               o_valid,
  output logic               o_exc,
  output logic [CAUSE_W-1:0] o_cause,
  output logic [PC_W-1:0]    o_pc
);
  logic               v_q;
  logic               x_q;
  logic [CAUSE_W-1:0] c_q;
  logic [PC_W-1:0]    p_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      v_q <= 1'b0;
      x_q <= 1'b0;
      c_q <= CAUSE_NONE;
      p_q <= '0;
    end else begin
      v_q <= in_valid;
      x_q <= in_valid & in_exc;
      c_q <= in_valid ? in_cause : CAUSE_NONE;
      p_q <= in_pc;
    end
  end

  // a locally raised fault only counts for a live, not yet flagged instruction
  logic local_hit;
  assign local_hit = v_q & fault & ~x_q;

  always_comb begin
    o_valid = v_q;
    o_exc   = x_q | local_hit;
    o_cause = local_hit ? CODE : c_q;
    o_pc    = p_q;
  end

  AST_EARLY_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_exc && !kill) |=> (o_exc && o_cause == $past(in_cause))) // R4
    else $error("earlier cause overwritten");
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic               m_valid,
  input  logic               m_exc,
  input  logic [CAUSE_W-1:0] m_cause,
  input  logic               irq,
  output logic               take,
  output logic [CAUSE_W-1:0] take_cause,
  output logic [PC_W-1:0]    target
);
  logic irq_hit;
  assign irq_hit = m_valid & irq;

  always_comb begin
    take       = irq_hit | (m_valid & m_exc);
    take_cause = irq_hit ? CAUSE_IRQ : m_cause;
    target     = HANDLER_PC;
  end
endmodule

// File: rtl/exc_retire_regs.sv
module exc_retire_regs
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [CAUSE_W-1:0] take_cause,
  input  logic               m_valid,
  input  logic [PC_W-1:0]    m_pc,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    epc,
  output logic               wb_valid,
  output logic [PC_W-1:0]    wb_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause    <= CAUSE_NONE;
      epc      <= '0;
      wb_valid <= 1'b0;
      wb_pc    <= '0;
    end else begin
      wb_valid <= m_valid & ~take;
      wb_pc    <= m_pc;
      if (take) begin
        cause <= take_cause;
        epc   <= m_pc;
      end
    end
  end

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc == $past(m_pc))) // R7
    else $error("EPC not captured");
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(cause) && $stable(epc))) // R7
    else $error("Cause/EPC changed without commit");
  AST_NO_RETIRE_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> !wb_valid) // R9
    else $error("faulting instruction retired");
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               f_valid,
  input  logic [PC_W-1:0]    f_pc,
  input  logic               f_pc_fault,
  input  logic               d_illegal,
  input  logic               e_overflow,
  input  logic               m_addr_fault,
  input  logic               irq,
  output logic               redirect,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               wb_valid,
  output logic [PC_W-1:0]    wb_pc,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    epc
);
  logic               sv [NSTG];
  logic               sx [NSTG];
  logic [CAUSE_W-1:0] sc [NSTG];
  logic [PC_W-1:0]    sp [NSTG];
  logic [NSTG-1:0]    fault_vec;
  logic               take;
  logic [CAUSE_W-1:0] take_cause;

  assign fault_vec = {m_addr_fault, e_overflow, d_illegal, f_pc_fault};

  // fetch stage: combinational view of the instruction being fetched
  assign sv[0] = f_valid;
  assign sx[0] = f_valid & fault_vec[0];
  assign sc[0] = (f_valid & fault_vec[0]) ? stage_cause(0) : CAUSE_NONE;
  assign sp[0] = f_pc;

  for (genvar s = 1; s < NSTG; s++) begin : g_stage
    exc_stage #(.PC_W(PC_W), .CODE(stage_cause(s))) u_stage (
      .clk      (clk),
      .rst      (rst),
      .kill     (take),
      .in_valid (sv[s-1]),
      .in_exc   (sx[s-1]),
      .in_cause (sc[s-1]),
      .in_pc    (sp[s-1]),
      .fault    (fault_vec[s]),
      .o_valid  (sv[s]),
      .o_exc    (sx[s]),
      .o_cause  (sc[s]),
      .o_pc     (sp[s])
    );
  end

  exc_commit_arb #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_arb (
    .m_valid    (sv[COMMIT_STG]),
    .m_exc      (sx[COMMIT_STG]),
    .m_cause    (sc[COMMIT_STG]),
    .irq        (irq),
    .take       (take),
    .take_cause (take_cause),
    .target     (redirect_pc)
  );

  exc_retire_regs #(.PC_W(PC_W)) u_retire (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .take_cause (take_cause),
    .m_valid    (sv[COMMIT_STG]),
    .m_pc       (sp[COMMIT_STG]),
    .cause      (cause),
    .epc        (epc),
    .wb_valid   (wb_valid),
    .wb_pc      (wb_pc)
  );

  assign redirect = take;

  AST_KILL_DRAINS: assert property (@(posedge clk) disable iff (rst)
    take |=> (!sv[1] && !sv[2] && !sv[3])) // R8
    else $error("younger stages survived a commit");
  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (rst)
    (irq && sv[COMMIT_STG]) |-> (redirect && take_cause == CAUSE_IRQ)) // R6
    else $error("interrupt not prioritised");
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !sv[COMMIT_STG] |-> !redirect) // R11
    else $error("commit with empty memory stage");
endmodule

// File: tb/sim_exc_commit_ctrl.sv
module sim_exc_commit_ctrl;
  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] HPC = 32'h0000_0180;

  logic            clk = 1'b0;
  logic            rst;
  logic            f_valid, f_pc_fault, d_illegal, e_overflow, m_addr_fault, irq;
  logic [PC_W-1:0] f_pc;
  logic            redirect, wb_valid;
  logic [PC_W-1:0] redirect_pc, wb_pc, epc;
  logic [3:0]      cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HPC)) u0 (
    .clk(clk), .rst(rst), .f_valid(f_valid), .f_pc(f_pc), .f_pc_fault(f_pc_fault),
    .d_illegal(d_illegal), .e_overflow(e_overflow), .m_addr_fault(m_addr_fault),
    .irq(irq), .redirect(redirect), .redirect_pc(redirect_pc), .wb_valid(wb_valid),
    .wb_pc(wb_pc), .cause(cause), .epc(epc)
  );

  // reference model state (decode, execute, memory)
  bit              mv [1:3];
  bit              mx [1:3];
  logic [3:0]      mc [1:3];
  logic [PC_W-1:0] mp [1:3];
  logic [3:0]      e_cause;
  logic [PC_W-1:0] e_epc, e_wbp;
  bit              e_wbv;
  bit              seen_redirect;
  logic [PC_W-1:0] pc_ctr = 32'h1000;

  function automatic logic [3:0] code_of(int s);
    case (s)
      0: return 4'h4;
      1: return 4'hA;
      2: return 4'hC;
      3: return 4'h5;
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 1; k <= 3; k++) begin
      mv[k] = 0; mx[k] = 0; mc[k] = 0; mp[k] = 0;
    end
    e_cause = 0; e_epc = 0; e_wbv = 0; e_wbp = 0;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(bit fv, logic [PC_W-1:0] pc, bit pf, bit di, bit eo, bit ma, bit ir);
    bit              cv [0:3];
    bit              cx [0:3];
    logic [3:0]      cc [0:3];
    logic [PC_W-1:0] cp [0:3];
    bit              flt [0:3];
    bit              tk;
    check("R5", {28'h0, cause}, {28'h0, e_cause});
    check("R7", epc, e_epc);
    check("R9", {31'h0, wb_valid}, {31'h0, e_wbv});
    if (e_wbv) check("R2", wb_pc, e_wbp);
    f_valid = fv; f_pc = pc; f_pc_fault = pf; d_illegal = di;
    e_overflow = eo; m_addr_fault = ma; irq = ir;
    #1;
    flt[0] = pf; flt[1] = di; flt[2] = eo; flt[3] = ma;
    cv[0] = fv; cx[0] = fv & pf; cc[0] = (fv & pf) ? code_of(0) : 4'h0; cp[0] = pc;
    for (int k = 1; k <= 3; k++) begin
      cv[k] = mv[k]; cp[k] = mp[k];
      if (mv[k] && !mx[k] && flt[k]) begin cx[k] = 1; cc[k] = code_of(k); end
      else begin cx[k] = mx[k]; cc[k] = mc[k]; end
    end
    tk = cv[3] & (cx[3] | ir);
    check("R3", {31'h0, redirect}, {31'h0, tk});
    if (tk) check("R10", redirect_pc, HPC);
    seen_redirect = redirect;
    if (tk) begin
      e_cause = ir ? 4'h1 : cc[3];
      e_epc = cp[3];
      e_wbv = 0;
      for (int k = 1; k <= 3; k++) begin
        mv[k] = 0; mx[k] = 0; mc[k] = 0; mp[k] = 0;
      end
    end else begin
      e_wbv = cv[3]; e_wbp = cp[3];
      for (int k = 3; k >= 1; k--) begin
        mv[k] = cv[k-1]; mx[k] = cv[k-1] & cx[k-1];
        mc[k] = cv[k-1] ? cc[k-1] : 4'h0; mp[k] = cp[k-1];
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int redirects;
    int retires;
    void'($urandom(32'd1234));
    rst = 1; f_valid = 0; f_pc = 0; f_pc_fault = 0; d_illegal = 0;
    e_overflow = 0; m_addr_fault = 0; irq = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {28'h0, cause}, 0);
    check("R1", epc, 0);
    check("R1", {31'h0, wb_valid}, 0);
    check("R1", {31'h0, redirect}, 0);
    rst = 0;

    // earliest stage wins: fetch, decode, execute, memory all fault on one instruction
    idle(4);
    step(1, 32'h100, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R4", {28'h0, cause}, 4'h4);
    check("R7", epc, 32'h100);

    // interrupt beats a data address fault at commit
    idle(4);
    step(1, 32'h200, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R6", {28'h0, cause}, 4'h1);
    check("R6", epc, 32'h200);

    // interrupt with empty memory stage is ignored
    idle(4);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R6", {31'h0, seen_redirect}, 0);

    // kill: flagged younger instruction must not fire, nothing retires
    idle(4);
    step(1, 32'h300, 0, 0, 0, 0, 0);
    step(1, 32'h304, 1, 0, 0, 0, 0);
    step(1, 32'h308, 0, 0, 1, 0, 0);
    step(1, 32'h30C, 0, 0, 0, 0, 0);
    redirects = 0; retires = 0;
    for (int i = 0; i < 4; i++) begin
      if (wb_valid) retires++;
      step(0, 0, 0, 0, 0, 0, 0);
      if (seen_redirect) redirects++;
    end
    check("R8", redirects, 0);
    check("R8", retires, 0);
    check("R5", {28'h0, cause}, 4'hC);
    check("R7", epc, 32'h300);

    // faults on empty stages are ignored; clean instruction retires at t+4
    idle(4);
    step(0, 0, 1, 1, 1, 1, 0);
    step(0, 0, 1, 1, 1, 1, 0);
    step(1, 32'h400, 0, 0, 0, 0, 0);
    idle(3);
    check("R11", {31'h0, wb_valid}, 1);
    check("R2", wb_pc, 32'h400);
    check("R11", {28'h0, cause}, 4'hC);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit fv;
      fv = ($urandom % 10) < 8;
      step(fv, pc_ctr, fv && (($urandom % 16) == 0), ($urandom % 14) == 0,
           ($urandom % 14) == 0, ($urandom % 14) == 0, ($urandom % 30) == 0);
      pc_ctr += 4;
    end
    idle(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule